// File: doc/BRIEF.md
# Exception Entry Sequencer

This block decides, cycle by cycle, whether a pending processor exception is taken, and performs the entry when one is. It holds the machine state register, the saved-address register and the saved-status register. A request vector carries one line per exception type. The block filters the requests through the enable bits of the current machine state and through the retirement condition. It picks one request by fixed priority. In the following cycle it presents the saved registers, the rewritten machine state and a fetch redirect address.

A machine check that arrives while machine checks are disabled does not vector. It freezes the block in a sticky checkstop state. A return-from-interrupt input copies the saved status bits back into the machine state and redirects fetch to the saved address. A load port writes the machine state directly.

Bit numbering in this document is big-endian: bit 0 is the most significant bit of the 32-bit word, so bit n sits at vector index 31-n. The machine state bits used are:

| Bit | Name | Meaning |
|---|---|---|
| 6 | VEC | vector unit available |
| 18 | FP | floating-point available |
| 19 | ME | machine check enable |
| 20 | FE0 | floating-point exception mode, bit 0 |
| 21 | SE | single-step trace |
| 22 | BE | branch trace |
| 23 | FE1 | floating-point exception mode, bit 1 |
| 25 | IP | vector base select |
| 26 | IR | instruction translation |
| 27 | DR | data translation |
| 30 | RI | recoverable |

The request index, with its type and vector offset, is:

| Index | Type | Vector offset |
|---|---|---|
| 0 | system reset | 0x100 |
| 1 | machine check | 0x200 |
| 2 | instruction storage | 0x400 |
| 3 | FP unavailable | 0x800 |
| 4 | vector unavailable | 0xF20 |
| 5 | program | 0x700 |
| 6 | system call | 0xC00 |
| 7 | data storage | 0x300 |
| 8 | trace | 0xD00 |

Top module: `exc_entry_seq`

## Requirements
- R1: While rst_n is low and after reset, msr = 0x0000_0040 (IP set), srr0 = 0, srr1 = 0, redirect_vld = 0, taken = 0 and checkstop = 0.
- R2: When several eligible requests are present in the same cycle, the lowest index wins. At most one entry happens per cycle, and taken is the one-hot of the winning index.
- R3: Indices 2 to 8 are eligible only while retire_ok is high. Indices 0 and 1 do not depend on retire_ok.
- R4: Index 3 is ignored while MSR bit 18 (FP) is set. Index 4 is ignored while MSR bit 6 (VEC) is set.
- R5: Index 5 with prog_ieee high is ignored when MSR bits 20 and 23 are both clear. Index 5 with prog_ieee low is always eligible.
- R6: Index 8 is eligible only when MSR bit 21 or bit 22 is set.
- R7: On entry, SRR1 bits 0 and 7 to 9 are zero. SRR1 bits 1 to 5 take exc_info[10:6] in order, and bits 10 to 15 take exc_info[5:0] in order. Bits 6 and 16 to 31 copy the old MSR.
- R8: On entry, SRR0 takes pc_next for indices 0, 1, 6 and 8, and takes pc_cur for all other indices.
- R9: On entry, the new MSR is the old MSR with bits 6, 18, 20, 21, 22, 23, 26, 27 and 30 cleared; IR and DR are always cleared.
- R10: One cycle after the request cycle, redirect_vld is high and redirect_addr equals the vector offset plus a base. The base is 0xFFF0_0000 when MSR bit 25 was set and 0 otherwise.
- R11: A taken machine check with MSR bit 19 clear sets checkstop, which stays set until reset. It issues no redirect and leaves msr, srr0 and srr1 unchanged. While checkstop is set, no further entry or return happens.
- R12: rfi with no entry in the same cycle does two things. It replaces MSR bits 6 and 16 to 31 with the SRR1 bits at the same positions, and it redirects to srr0 with taken = 0. An entry in the same cycle wins over rfi.
- R13: msr_ld writes msr_ld_val into the MSR when neither an entry nor rfi happens in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| exc_req | input | 9 | one request line per exception index |
| prog_ieee | input | 1 | the program request is an IEEE floating-point enabled kind |
| retire_ok | input | 1 | faulting instruction is next to retire and older exceptions are done |
| pc_cur | input | 32 | address of the faulting instruction |
| pc_next | input | 32 | address of the next instruction |
| exc_info | input | 11 | exception-specific status bits for SRR1 |
| rfi | input | 1 | return from interrupt |
| msr_ld | input | 1 | direct MSR write strobe |
| msr_ld_val | input | 32 | value for the direct MSR write |
| msr | output | 32 | current machine state |
| srr0 | output | 32 | saved address |
| srr1 | output | 32 | saved status |
| redirect_vld | output | 1 | fetch redirect valid, one cycle |
| redirect_addr | output | 32 | fetch redirect target |
| taken | output | 9 | one-hot index of the entry just performed |
| checkstop | output | 1 | sticky stop state |

## Verification
The assertions assume that the request, retire and address inputs are stable across each rising edge. They also assume that the IP bit of the machine state is never in the entry clear set, so that the vector base seen after entry matches the one used to form the address. The bench changes every input on the falling edge only. It reloads the machine state through the load port before each request, and it resets between sweep points, so that each check starts from a state it knows. The sweep covers every index against sixteen scattered machine-state patterns, with both retire and IEEE settings, which reaches both values of every enable bit.

// File: rtl/exc_pkg.sv
package exc_pkg;
   localparam int XLEN   = 32;
   localparam int NEXC   = 9;
   localparam int IDX_W  = 4;
   localparam int VOFF_W = 12;

   typedef enum logic [IDX_W-1:0] {
      EX_RESET = 4'd0,
      EX_MCHK  = 4'd1,
      EX_ISI   = 4'd2,
      EX_FPU   = 4'd3,
      EX_VEC   = 4'd4,
      EX_PROG  = 4'd5,
      EX_SC    = 4'd6,
      EX_DSI   = 4'd7,
      EX_TRACE = 4'd8
   } exc_e;

   // big-endian bit number to vector index
   function automatic int bi(int n);
      return XLEN - 1 - n;
   endfunction

   localparam int MB_VEC = XLEN - 1 - 6;
   localparam int MB_FP  = XLEN - 1 - 18;
   localparam int MB_ME  = XLEN - 1 - 19;
   localparam int MB_FE0 = XLEN - 1 - 20;
   localparam int MB_SE  = XLEN - 1 - 21;
   localparam int MB_BE  = XLEN - 1 - 22;
   localparam int MB_FE1 = XLEN - 1 - 23;
   localparam int MB_IP  = XLEN - 1 - 25;
   localparam int MB_IR  = XLEN - 1 - 26;
   localparam int MB_DR  = XLEN - 1 - 27;
   localparam int MB_RI  = XLEN - 1 - 30;

   // saved-status slot kinds
   localparam int SK_ZERO = 0;
   localparam int SK_INFO = 1;
   localparam int SK_COPY = 2;

   function automatic int srr1_kind(int n);
      if (n == 6 || n >= 16)               return SK_COPY;
      if ((n >= 1 && n <= 5) || (n >= 10 && n <= 15)) return SK_INFO;
      return SK_ZERO;
   endfunction

   // position of an info slot counted from the most significant info bit
   function automatic int info_slot(int n);
      if (n >= 1 && n <= 5)   return n - 1;
      if (n >= 10 && n <= 15) return n - 5;
      return 0;
   endfunction

   function automatic logic [XLEN-1:0] copy_mask();
      logic [XLEN-1:0] m;
      m = '0;
      for (int n = 0; n < XLEN; n++)
         if (srr1_kind(n) == SK_COPY) m[bi(n)] = 1'b1;
      return m;
   endfunction

   function automatic logic [VOFF_W-1:0] vec_off(exc_e e);
      case (e)
         EX_RESET: return 12'h100;
         EX_MCHK:  return 12'h200;
         EX_ISI:   return 12'h400;
         EX_FPU:   return 12'h800;
         EX_VEC:   return 12'hF20;
         EX_PROG:  return 12'h700;
         EX_SC:    return 12'hC00;
         EX_DSI:   return 12'h300;
         EX_TRACE: return 12'hD00;
         default:  return 12'h000;
      endcase
   endfunction

   function automatic logic save_next(exc_e e);
      return (e == EX_RESET) || (e == EX_MCHK) || (e == EX_SC) || (e == EX_TRACE);
   endfunction
endpackage

// File: rtl/exc_select.sv
module exc_select
   import exc_pkg::*;
#(
   parameter int PRIO_STYLE = 0
)(
   input  logic [NEXC-1:0] req,
   input  logic            retire_ok,
   input  logic            prog_ieee,
   input  logic            halted,
   input  logic            m_fp,
   input  logic            m_vec,
   input  logic            m_fe0,
   input  logic            m_fe1,
   input  logic            m_se,
   input  logic            m_be,
   output logic [NEXC-1:0] grant,
   output exc_e            idx,
   output logic            valid
);
   logic [NEXC-1:0] elig;

   if (PRIO_STYLE != 0 && PRIO_STYLE != 1) begin : g_bad_style
      $error("exc_select: PRIO_STYLE must be 0 or 1");
   end

   for (genvar k = 0; k < NEXC; k++) begin : g_elig
      logic en;
      logic gate;
      if (k == int'(EX_FPU)) begin : g_fpu
         assign en = ~m_fp;
      end else if (k == int'(EX_VEC)) begin : g_vec
         assign en = ~m_vec;
      end else if (k == int'(EX_PROG)) begin : g_prog
         assign en = ~prog_ieee | m_fe0 | m_fe1;
      end else if (k == int'(EX_TRACE)) begin : g_trace
         assign en = m_se | m_be;
      end else begin : g_always
         assign en = 1'b1;
      end
      if (k == int'(EX_RESET) || k == int'(EX_MCHK)) begin : g_async
         assign gate = 1'b1;
      end else begin : g_retire
         assign gate = retire_ok;
      end
      assign elig[k] = req[k] & en & gate & ~halted;
   end

   if (PRIO_STYLE == 0) begin : g_chain
      always_comb begin
         grant = '0;
         for (int k = NEXC - 1; k >= 0; k--)
            if (elig[k]) begin
               grant    = '0;
               grant[k] = 1'b1;
            end
      end
   end else begin : g_isolate
      assign grant = elig & (~elig + NEXC'(1));
   end

   always_comb begin
      idx = EX_RESET;
      for (int k = 0; k < NEXC; k++)
         if (grant[k]) idx = exc_e'(IDX_W'(k));
   end

   assign valid = |elig;
endmodule

// File: rtl/exc_frame_build.sv
module exc_frame_build
   import exc_pkg::*;
#(
   parameter logic [XLEN-1:0] LOW_BASE  = 32'h0000_0000,
   parameter logic [XLEN-1:0] HIGH_BASE = 32'hFFF0_0000,
   parameter logic [XLEN-1:0] ENTRY_CLR = 32'h0200_2F32,
   parameter int              INFO_W    = 11
)(
   input  exc_e              idx,
   input  logic [XLEN-1:0]   msr,
   input  logic [XLEN-1:0]   pc_cur,
   input  logic [XLEN-1:0]   pc_next,
   input  logic [INFO_W-1:0] info,
   output logic [XLEN-1:0]   srr0_n,
   output logic [XLEN-1:0]   srr1_n,
   output logic [XLEN-1:0]   msr_n,
   output logic [XLEN-1:0]   vaddr,
   output logic              halt
);
   localparam int BASE_LOW_BITS = 20;

   if (INFO_W != 11) begin : g_bad_info
      $error("exc_frame_build: INFO_W must be 11");
   end
   if (ENTRY_CLR[MB_IR] != 1'b1 || ENTRY_CLR[MB_DR] != 1'b1) begin : g_bad_clr
      $error("exc_frame_build: ENTRY_CLR must clear IR and DR");
   end
   if (ENTRY_CLR[MB_IP] != 1'b0) begin : g_bad_ip
      $error("exc_frame_build: ENTRY_CLR must keep IP");
   end
   if (LOW_BASE[BASE_LOW_BITS-1:0] != '0 || HIGH_BASE[BASE_LOW_BITS-1:0] != '0) begin : g_bad_base
      $error("exc_frame_build: vector bases must be 1 MiB aligned");
   end

   for (genvar n = 0; n < XLEN; n++) begin : g_srr1
      localparam int KIND = srr1_kind(n);
      localparam int SLOT = info_slot(n);
      if (KIND == SK_COPY) begin : g_copy
         assign srr1_n[XLEN-1-n] = msr[XLEN-1-n];
      end else if (KIND == SK_INFO) begin : g_info
         assign srr1_n[XLEN-1-n] = info[INFO_W-1-SLOT];
      end else begin : g_zero
         assign srr1_n[XLEN-1-n] = 1'b0;
      end
   end

   assign srr0_n = save_next(idx) ? pc_next : pc_cur;
   assign msr_n  = msr & ~ENTRY_CLR;
   assign vaddr  = (msr[MB_IP] ? HIGH_BASE : LOW_BASE)
                 + {{(XLEN-VOFF_W){1'b0}}, vec_off(idx)};
   assign halt   = (idx == EX_MCHK) & ~msr[MB_ME];
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
   import exc_pkg::*;
#(
   parameter logic [31:0] RST_MSR    = 32'h0000_0040,
   parameter logic [31:0] LOW_BASE   = 32'h0000_0000,
   parameter logic [31:0] HIGH_BASE  = 32'hFFF0_0000,
   parameter logic [31:0] ENTRY_CLR  = 32'h0200_2F32,
   parameter int          PRIO_STYLE = 0
)(
   input  logic        clk,
   input  logic        rst_n,
   input  logic [8:0]  exc_req,
   input  logic        prog_ieee,
   input  logic        retire_ok,
   input  logic [31:0] pc_cur,
   input  logic [31:0] pc_next,
   input  logic [10:0] exc_info,
   input  logic        rfi,
   input  logic        msr_ld,
   input  logic [31:0] msr_ld_val,
   output logic [31:0] msr,
   output logic [31:0] srr0,
   output logic [31:0] srr1,
   output logic        redirect_vld,
   output logic [31:0] redirect_addr,
   output logic [8:0]  taken,
   output logic        checkstop
);
   localparam logic [XLEN-1:0] COPY_M = copy_mask();

   if (NEXC != 9 || XLEN != 32) begin : g_bad_pkg
      $error("exc_entry_seq: port widths assume 9 types and 32-bit words");
   end

   logic [NEXC-1:0] grant;
   exc_e            sel_idx;
   logic            sel_vld;
   logic [XLEN-1:0] srr0_n, srr1_n, msr_n, vaddr;
   logic            halt;

   exc_select #(.PRIO_STYLE(PRIO_STYLE)) u_sel (
      .req       (exc_req),
      .retire_ok (retire_ok),
      .prog_ieee (prog_ieee),
      .halted    (checkstop),
      .m_fp      (msr[MB_FP]),
      .m_vec     (msr[MB_VEC]),
      .m_fe0     (msr[MB_FE0]),
      .m_fe1     (msr[MB_FE1]),
      .m_se      (msr[MB_SE]),
      .m_be      (msr[MB_BE]),
      .grant     (grant),
      .idx       (sel_idx),
      .valid     (sel_vld)
   );

   exc_frame_build #(
      .LOW_BASE  (LOW_BASE),
      .HIGH_BASE (HIGH_BASE),
      .ENTRY_CLR (ENTRY_CLR),
      .INFO_W    (11)
   ) u_frame (
      .idx     (sel_idx),
      .msr     (msr),
      .pc_cur  (pc_cur),
      .pc_next (pc_next),
      .info    (exc_info),
      .srr0_n  (srr0_n),
      .srr1_n  (srr1_n),
      .msr_n   (msr_n),
      .vaddr   (vaddr),
      .halt    (halt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         msr           <= RST_MSR;
         srr0          <= '0;
         srr1          <= '0;
         redirect_vld  <= 1'b0;
         redirect_addr <= '0;
         taken         <= '0;
         checkstop     <= 1'b0;
      end else begin
         redirect_vld <= 1'b0;
         taken        <= '0;
         if (!checkstop) begin
            if (sel_vld) begin
               if (halt) begin
                  checkstop <= 1'b1;
               end else begin
                  srr0          <= srr0_n;
                  srr1          <= srr1_n;
                  msr           <= msr_n;
                  redirect_vld  <= 1'b1;
                  redirect_addr <= vaddr;
                  taken         <= grant;
               end
            end else if (rfi) begin
               msr           <= (msr & ~COPY_M) | (srr1 & COPY_M);
               redirect_vld  <= 1'b1;
               redirect_addr <= srr0;
            end else if (msr_ld) begin
               msr <= msr_ld_val;
            end
         end
      end
   end

   a_r2_taken_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(taken));

   a_r3_retire_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (|taken[8:2]) |-> $past(retire_ok));

   a_r7_zero_slots: assert property (@(posedge clk) disable iff (!rst_n)
      (srr1[31] == 1'b0) && (srr1[24:22] == 3'b000));

   a_r9_translation_off: assert property (@(posedge clk) disable iff (!rst_n)
      (|taken) |-> (!msr[MB_IR] && !msr[MB_DR]));

   a_r10_base_select: assert property (@(posedge clk) disable iff (!rst_n)
      (|taken) |-> (redirect_addr[31:20] == (msr[MB_IP] ? HIGH_BASE[31:20] : LOW_BASE[31:20])));

   a_r10_redirect_with_taken: assert property (@(posedge clk) disable iff (!rst_n)
      (|taken) |-> redirect_vld);

   a_r11_checkstop_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      checkstop |=> checkstop);

   a_r11_no_redirect_stopped: assert property (@(posedge clk) disable iff (!rst_n)
      checkstop |-> !redirect_vld);

   a_r11_state_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(checkstop) |-> ($stable(msr) && $stable(srr0) && $stable(srr1)));
endmodule

// File: tb/exc_entry_seq_bench.sv
module exc_entry_seq_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [8:0]  exc_req = '0;
   logic        prog_ieee = 1'b0, retire_ok = 1'b0, rfi = 1'b0, msr_ld = 1'b0;
   logic [31:0] pc_cur = '0, pc_next = '0, msr_ld_val = '0;
   logic [10:0] exc_info = '0;
   logic [31:0] msr, srr0, srr1, redirect_addr;
   logic        redirect_vld, checkstop;
   logic [8:0]  taken;

   int vectors = 0, errors = 0, cyc = 0;

   exc_entry_seq u_exc_entry_seq (.*);

   always #10 clk = ~clk;

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         vectors++; errors++;
         $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cyc);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic int bp(int n); return 31 - n; endfunction

   function automatic logic [31:0] m_copy();
      logic [31:0] m = '0;
      m[bp(6)] = 1'b1;
      for (int n = 16; n < 32; n++) m[bp(n)] = 1'b1;
      return m;
   endfunction

   function automatic logic [31:0] m_clr();
      logic [31:0] m = '0;
      m[bp(6)] = 1; m[bp(18)] = 1; m[bp(20)] = 1; m[bp(21)] = 1; m[bp(22)] = 1;
      m[bp(23)] = 1; m[bp(26)] = 1; m[bp(27)] = 1; m[bp(30)] = 1;
      return m;
   endfunction

   function automatic logic [31:0] exp_srr1(logic [31:0] m, logic [10:0] inf);
      logic [31:0] s = '0;
      for (int n = 0; n < 32; n++) begin
         if (n == 6 || n >= 16)       s[bp(n)] = m[bp(n)];
         else if (n >= 1 && n <= 5)   s[bp(n)] = inf[10 - (n - 1)];
         else if (n >= 10 && n <= 15) s[bp(n)] = inf[10 - (n - 5)];
      end
      return s;
   endfunction

   function automatic logic [31:0] voff(int k);
      case (k)
         0: return 32'h100; 1: return 32'h200; 2: return 32'h400;
         3: return 32'h800; 4: return 32'hF20; 5: return 32'h700;
         6: return 32'hC00; 7: return 32'h300; default: return 32'hD00;
      endcase
   endfunction

   function automatic bit eligible(int k, logic [31:0] m, bit ieee, bit ret);
      bit en = 1;
      if (k == 3) en = !m[bp(18)];                        // R4
      if (k == 4) en = !m[bp(6)];                         // R4
      if (k == 5) en = !ieee || m[bp(20)] || m[bp(23)];   // R5
      if (k == 8) en = m[bp(21)] || m[bp(22)];            // R6
      if (k >= 2 && !ret) en = 0;                         // R3
      return en;
   endfunction

   task automatic do_reset();
      @(negedge clk);
      rst_n = 0; exc_req = '0; rfi = 0; msr_ld = 0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1;
   endtask

   task automatic load_msr(logic [31:0] m);
      msr_ld = 1; msr_ld_val = m;
      @(negedge clk);
      msr_ld = 0;
      chk("R13 msr load", msr, m);
   endtask

   task automatic run_one(int k, logic [31:0] m, bit ieee, bit ret);
      bit          take;
      logic [31:0] pcc, pcn;
      logic [10:0] inf;
      do_reset();
      load_msr(m);
      pcc = 32'h4000_0000 + 32'(k) * 32'h24 + m[15:0];
      pcn = pcc + 32'h4;
      inf = m[26:16] ^ 11'(k * 37);
      exc_req = 9'(1 << k); prog_ieee = ieee; retire_ok = ret;
      pc_cur = pcc; pc_next = pcn; exc_info = inf;
      take = eligible(k, m, ieee, ret);
      @(posedge clk); #2;
      if (take && k == 1 && !m[bp(19)]) begin
         chk("R11 checkstop set", 32'(checkstop), 1);
         chk("R11 no redirect", 32'(redirect_vld), 0);
         chk("R11 msr kept", msr, m);
         chk("R11 srr0 kept", srr0, 0);
         chk("R11 srr1 kept", srr1, 0);
         @(negedge clk);
         exc_req = 9'h003;
         @(posedge clk); #2;
         chk("R11 sticky", 32'(checkstop), 1);
         chk("R11 no entry when stopped", 32'(redirect_vld), 0);
      end else if (take) begin
         chk("R10 redirect valid", 32'(redirect_vld), 1);
         chk("R10 redirect addr", redirect_addr,
             (m[bp(25)] ? 32'hFFF0_0000 : 32'h0) + voff(k));
         chk("R2 taken", 32'(taken), 32'(1 << k));
         chk("R8 srr0", srr0, (k == 0 || k == 1 || k == 6 || k == 8) ? pcn : pcc);
         chk("R7 srr1", srr1, exp_srr1(m, inf));
         chk("R9 new msr", msr, m & ~m_clr());
         chk("R11 no checkstop", 32'(checkstop), 0);
      end else begin
         chk("R3 R4 R5 R6 ignored: no redirect", 32'(redirect_vld), 0);
         chk("R3 R4 R5 R6 ignored: msr kept", msr, m);
         chk("R3 R4 R5 R6 ignored: srr0 kept", srr0, 0);
      end
      @(negedge clk);
      exc_req = '0;
   endtask

   initial begin
      logic [31:0] m, after, s1;
      @(negedge clk);
      @(negedge clk);
      #0;
      chk("R1 reset msr", msr, 32'h0000_0040);
      chk("R1 reset srr0", srr0, 0);
      chk("R1 reset srr1", srr1, 0);
      chk("R1 reset redirect", 32'(redirect_vld), 0);
      chk("R1 reset taken", 32'(taken), 0);
      chk("R1 reset checkstop", 32'(checkstop), 0);
      rst_n = 1;

      for (int p = 0; p < 16; p++)
         for (int k = 0; k < 9; k++)
            for (int r = 0; r < 2; r++)
               for (int q = 0; q < 2; q++)
                  run_one(k, (32'h9E37_79B9 * 32'(p + 1)) ^ (32'h0137_0000 << (p % 5)), q[0], r[0]);

      // R2 priority: requests from index k upward, all enabled
      m = 32'h0000_1C00 | (32'h1 << bp(19)) | (32'h1 << bp(21));
      m = m & ~(32'h1 << bp(18)) & ~(32'h1 << bp(6));
      for (int k = 0; k < 9; k++) begin
         do_reset();
         load_msr(m);
         exc_req = 9'h1FF << k; retire_ok = 1; prog_ieee = 0;
         @(posedge clk); #2;
         chk("R2 priority winner", 32'(taken), 32'(1 << k));
         @(negedge clk);
         exc_req = '0;
      end

      // R12 return restores copied bits and redirects to srr0
      do_reset();
      m = 32'h0260_FF72;
      load_msr(m);
      pc_cur = 32'h0000_5000; pc_next = 32'h0000_5004; exc_info = 11'h5A5;
      exc_req = 9'h040; retire_ok = 1;
      @(negedge clk);
      exc_req = '0;
      after = msr; s1 = srr1;
      rfi = 1;
      @(posedge clk); #2;
      chk("R12 rfi redirect", 32'(redirect_vld), 1);
      chk("R12 rfi addr", redirect_addr, 32'h0000_5004);
      chk("R12 rfi msr", msr, (after & ~m_copy()) | (s1 & m_copy()));
      chk("R12 rfi taken", 32'(taken), 0);
      @(negedge clk);
      rfi = 0;

      // R12 entry beats a simultaneous return
      do_reset();
      load_msr(32'h0000_0000);
      exc_req = 9'h040; rfi = 1;
      @(posedge clk); #2;
      chk("R12 entry over rfi", redirect_addr, 32'h0000_0C00);
      chk("R12 entry over rfi taken", 32'(taken), 32'h040);
      @(negedge clk);
      exc_req = '0; rfi = 0;

      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule